// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block is a single-beat bus master for an external bus whose data path is 32 bits wide. A client hands it one access of one to four bytes: address, lane-aligned write data, byte count and direction. The master takes part in a request/grant/busy arbitration scheme, opens each bus transaction with a one-clock start strobe, and then waits through any number of wait states for the transfer acknowledge.

Every access is first sent as if the target were a 32-bit port. The addressed memory returns a port-size code, which the master samples in the cycle that acknowledges the first transaction. If that code names a 16-bit or 8-bit port and bytes are still left to move, the master issues follow-up transactions back to back. Each one starts at the next byte address and carries the remaining byte count. The master keeps its bus-busy output asserted through the whole series, so no other master can get in between. Read bytes from all transactions are gathered into one big-endian 32-bit result, which is returned with a single done pulse.

A retry on the first transaction sends the master back to arbitration for the same transaction. A retry on any follow-up transaction of a split access ends the whole access with an error pulse.

Top module: `dbs_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1 and bus_req, bus_busy_out, bus_start, rsp_done and rsp_err are all 0.
- R2: When a request is accepted (req_valid high while req_ready is high), bus_req is high from the next cycle up to and including the first cycle in which bus_grant is 1 and bus_busy_in is 0. bus_start does not rise before that cycle.
- R3: bus_start is high for exactly one cycle at the beginning of every transaction, including each follow-up transaction. bus_addr and bus_tsize stay unchanged until the acknowledge. bus_tsize gives the bytes still to move: 2'b01 means 1, 2'b10 means 2, 2'b11 means 3 and 2'b00 means 4.
- R4: A transaction ends in the first cycle after its start cycle in which bus_ack or bus_retry is high. Until then the master holds all bus outputs (wait states).
- R5: bus_port is sampled in the cycle of the first acknowledge. 2'b01 means an 8-bit port, 2'b10 a 16-bit port, and 2'b00 or 2'b11 a 32-bit port. A 32-bit port moves all remaining bytes. A 16-bit port moves bytes up to the end of the aligned halfword. An 8-bit port moves one byte. Each follow-up transaction's address is the previous one plus the bytes moved.
- R6: Between the transactions of one access, bus_busy_out stays high and bus_req and req_ready stay low. The next bus_start comes in the cycle after the acknowledge.
- R7: Byte lane k of a 32-bit data word is bits [31-8k:24-8k]. A write of the byte at address x goes on lane x[1:0] for a 32-bit port, on lane x[0] for a 16-bit port and on lane 0 for an 8-bit port. req_wdata carries each byte in lane x[1:0].
- R8: rsp_done is a one-cycle pulse in the cycle after the final acknowledge. bus_busy_out is still high in that cycle and low in the next. For reads, rsp_rdata holds each requested byte in lane x[1:0], taken from the lane that R7 gives for the port, and the lanes that were not requested are zero.
- R9: A retry on the first transaction gives no error. bus_busy_out drops, bus_req rises in the next cycle, and the same address and size are started again after a new grant.
- R10: A retry on a follow-up transaction gives a one-cycle rsp_err pulse in the next cycle with no rsp_done. No further transaction starts, and bus_busy_out drops one cycle later.

Accesses must not cross a 32-bit word boundary (address low bits plus byte count at most 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Master idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Byte count (01/10/11/00 = 1/2/3/4) |
| req_wdata | input | DATA_W | Lane-aligned write data |
| rsp_done | output | 1 | Access completed pulse |
| rsp_err | output | 1 | Access aborted by late retry |
| rsp_rdata | output | DATA_W | Assembled read data |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_busy_in | input | 1 | Bus busy driven by another master |
| bus_busy_out | output | 1 | Bus busy driven by this master |
| bus_start | output | 1 | Transaction start strobe |
| bus_addr | output | ADDR_W | Transaction address |
| bus_write | output | 1 | Transaction direction |
| bus_tsize | output | 2 | Bytes remaining, encoded as req_size |
| bus_wdata | output | DATA_W | Steered write data |
| bus_rdata | input | DATA_W | Read data from memory |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_retry | input | 1 | Transfer retry |
| bus_port | input | 2 | Port-size code of the addressed memory |

## Verification
The bench targets the split boundaries. These include an odd start on a 16-bit port, which has to move one byte first and then two. They also include a 3-byte access and a port code of 2'b11. A master that advanced by the wrong amount would show a wrong address or size on the follow-up, or a wrong transaction count. Retries are injected both on the first transaction and on the second. Escalating the first retry, or merely restarting the second, shows up as a spurious or missing error and in the bytes left in memory. Grant is held back while another master is busy, and wait states are stretched. A design that dropped bus busy between split transactions, or started early, fails the cycle-by-cycle comparison. Lanes a read did not request must come back as zero even though the memory puts junk on them.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_START,
      ST_WAIT,
      ST_FIN
   } seq_state_e;

   typedef enum logic [1:0] {
      PW_WORD,
      PW_HALF,
      PW_BYTE
   } port_w_e;

   localparam logic [1:0] PCODE_BYTE = 2'b01;
   localparam logic [1:0] PCODE_HALF = 2'b10;

   // Port code to width class; unknown codes fall back to the full word.
   function automatic port_w_e decode_port(input logic [1:0] code);
      port_w_e pw;
      case (code)
         PCODE_BYTE: pw = PW_BYTE;
         PCODE_HALF: pw = PW_HALF;
         default:    pw = PW_WORD;
      endcase
      return pw;
   endfunction

   // Size code to byte count; 2'b00 stands for four bytes.
   function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
      return (code == 2'b00) ? 3'd4 : {1'b0, code};
   endfunction

   // Bytes moved by one transaction to a port of the given width.
   function automatic logic [2:0] beat_bytes(input port_w_e pw,
                                             input logic [2:0] rem,
                                             input logic odd);
      logic [2:0] n;
      case (pw)
         PW_WORD: n = rem;
         PW_HALF: n = odd ? 3'd1 : ((rem >= 3'd2) ? 3'd2 : rem);
         default: n = 3'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dbs_beat_track.sv
module dbs_beat_track
   import dbs_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              step,
   input  logic [1:0]        port_code,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [2:0]        rem,
   output logic              first,
   output port_w_e           eff_port,
   output logic [2:0]        beat_n,
   output logic              last
);

   port_w_e port_lat;

   always_comb begin
      eff_port = first ? decode_port(port_code) : port_lat;
      beat_n   = beat_bytes(eff_port, rem, cur_addr[0]);
      last     = (beat_n == rem);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         rem      <= '0;
         first    <= 1'b0;
         port_lat <= PW_WORD;
      end else if (load) begin
         cur_addr <= req_addr;
         rem      <= size_to_bytes(req_size);
         first    <= 1'b1;
         port_lat <= PW_WORD;
      end else if (step) begin
         if (first) begin
            port_lat <= eff_port;
         end
         first    <= 1'b0;
         cur_addr <= cur_addr + ADDR_W'(beat_n);
         rem      <= rem - beat_n;
      end
   end

   // R5
   addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (cur_addr[1:0] != $past(cur_addr[1:0])));

   // R5
   rem_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> ((rem < $past(rem)) && (rem != 3'd0)));

   // R3
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem <= 3'd4));

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
   import dbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       bus_grant,
   input  logic       bus_busy_in,
   input  logic       bus_ack,
   input  logic       bus_retry,
   input  logic       first,
   input  logic       last,
   output logic       load,
   output logic       step,
   output logic       req_ready,
   output logic       bus_req,
   output logic       bus_start,
   output logic       busy_out,
   output logic       rsp_done,
   output logic       rsp_err
);

   seq_state_e state, nxt;
   logic       err_q;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (req_valid) nxt = ST_ARB;
         ST_ARB:   if (bus_grant && !bus_busy_in) nxt = ST_START;
         ST_START: nxt = ST_WAIT;
         ST_WAIT: begin
            if (bus_retry) begin
               nxt = first ? ST_ARB : ST_FIN;
            end else if (bus_ack) begin
               nxt = last ? ST_FIN : ST_START;
            end
         end
         ST_FIN:   nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         err_q <= 1'b0;
      end else begin
         state <= nxt;
         if (load) begin
            err_q <= 1'b0;
         end else if (state == ST_WAIT && bus_retry && !first) begin
            err_q <= 1'b1;
         end
      end
   end

   always_comb begin
      load      = (state == ST_IDLE) && req_valid;
      step      = (state == ST_WAIT) && bus_ack && !bus_retry;
      req_ready = (state == ST_IDLE);
      bus_req   = (state == ST_ARB);
      bus_start = (state == ST_START);
      busy_out  = (state == ST_START) || (state == ST_WAIT) || (state == ST_FIN);
      rsp_done  = (state == ST_FIN) && !err_q;
      rsp_err   = (state == ST_FIN) && err_q;
   end

   // R3
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !bus_start);

   // R2
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !(bus_grant && !bus_busy_in)) |=> (bus_req && !bus_start));

   // R6
   atomic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (bus_start && busy_out && !bus_req && !req_ready));

   // R9
   first_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && bus_retry && first) |=> (bus_req && !busy_out && !rsp_err));

   // R10
   late_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && bus_retry && !first) |=> (rsp_err && !rsp_done && busy_out));

endmodule

// File: rtl/dbs_wr_steer.sv
module dbs_wr_steer #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        off,
   output logic [DATA_W-1:0] bus_wdata
);

   localparam int LANES = DATA_W / 8;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [1:0] src;
      always_comb begin
         if (L >= 2) begin
            src = 2'(L);
         end else if (L == 1) begin
            src = {off[1], 1'b1};
         end else begin
            src = off;
         end
      end
      assign bus_wdata[DATA_W-1-8*L -: 8] = wdata[DATA_W-1-8*src -: 8];
   end

endmodule

// File: rtl/dbs_rd_pack.sv
module dbs_rd_pack
   import dbs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [1:0]        off,
   input  logic [2:0]        beat_n,
   input  port_w_e           eff_port,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);

   localparam int LANES = DATA_W / 8;

   logic [3:0] lo, hi;
   assign lo = {2'b00, off};
   assign hi = lo + {1'b0, beat_n};

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic       hit;
      logic [7:0] src_byte;
      logic [7:0] lane_q;

      always_comb begin
         hit = (4'(L) >= lo) && (4'(L) < hi);
         case (eff_port)
            PW_WORD: src_byte = rdata[DATA_W-1-8*L -: 8];
            PW_HALF: src_byte = rdata[DATA_W-1-8*(L%2) -: 8];
            default: src_byte = rdata[DATA_W-1 -: 8];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (load) begin
            lane_q <= '0;
         end else if (step && hit) begin
            lane_q <= src_byte;
         end
      end

      assign result[DATA_W-1-8*L -: 8] = lane_q;
   end

   // R8
   pack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(result));

endmodule

// File: rtl/dbs_master.sv
module dbs_master
   import dbs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_req,
   input  logic              bus_grant,
   input  logic              bus_busy_in,
   output logic              bus_busy_out,
   output logic              bus_start,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_write,
   output logic [1:0]        bus_tsize,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   input  logic              bus_retry,
   input  logic [1:0]        bus_port
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dbs_master: DATA_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("dbs_master: ADDR_W must be at least 4");
   end

   logic              load, step, first, last;
   logic [ADDR_W-1:0] cur_addr;
   logic [2:0]        rem, beat_n;
   port_w_e           eff_port;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         write_q <= 1'b0;
      end else if (load) begin
         wdata_q <= req_wdata;
         write_q <= req_write;
      end
   end

   dbs_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .bus_grant   (bus_grant),
      .bus_busy_in (bus_busy_in),
      .bus_ack     (bus_ack),
      .bus_retry   (bus_retry),
      .first       (first),
      .last        (last),
      .load        (load),
      .step        (step),
      .req_ready   (req_ready),
      .bus_req     (bus_req),
      .bus_start   (bus_start),
      .busy_out    (bus_busy_out),
      .rsp_done    (rsp_done),
      .rsp_err     (rsp_err)
   );

   dbs_beat_track #(.ADDR_W(ADDR_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .step      (step),
      .port_code (bus_port),
      .cur_addr  (cur_addr),
      .rem       (rem),
      .first     (first),
      .eff_port  (eff_port),
      .beat_n    (beat_n),
      .last      (last)
   );

   dbs_wr_steer #(.DATA_W(DATA_W)) u_steer (
      .wdata     (wdata_q),
      .off       (cur_addr[1:0]),
      .bus_wdata (bus_wdata)
   );

   dbs_rd_pack #(.DATA_W(DATA_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .off      (cur_addr[1:0]),
      .beat_n   (beat_n),
      .eff_port (eff_port),
      .rdata    (bus_rdata),
      .result   (rsp_rdata)
   );

   assign bus_addr  = cur_addr;
   assign bus_tsize = rem[1:0];
   assign bus_write = write_q;

   // R3
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> ($stable(bus_addr) && $stable(bus_tsize)));

   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && !bus_busy_out));

   // R10
   err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |=> (!rsp_err && !bus_busy_out && !bus_start));

endmodule

// File: tb/tb_dbs_master.sv
`timescale 1ns/1ps
module tb_dbs_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_size = '0;
   logic        req_ready, rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic        bus_req, bus_busy_out, bus_start, bus_write;
   logic        bus_grant = 1'b1, bus_busy_in = 1'b0, bus_ack = 1'b0, bus_retry = 1'b0;
   logic [31:0] bus_addr, bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic [1:0]  bus_tsize;
   logic [1:0]  bus_port = 2'b00;

   always #4 clk = ~clk;

   dbs_master dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_req(bus_req), .bus_grant(bus_grant), .bus_busy_in(bus_busy_in),
      .bus_busy_out(bus_busy_out), .bus_start(bus_start), .bus_addr(bus_addr),
      .bus_write(bus_write), .bus_tsize(bus_tsize), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_retry(bus_retry),
      .bus_port(bus_port)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Width in bits of the port named by a code (R5 encoding).
   function automatic int port_bits(input logic [1:0] c);
      return (c == 2'b01) ? 8 : (c == 2'b10) ? 16 : 32;
   endfunction

   function automatic int moved(input int w, input int r, input int a);
      if (w == 32) return r;
      if (w == 16) return (a % 2 == 1) ? 1 : ((r >= 2) ? 2 : r);
      return 1;
   endfunction

   // ---------------- behavioural reference model ----------------
   int          m_ph, m_rem, m_first, m_w, m_err;
   logic [31:0] m_addr, m_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_rem = 0; m_first = 0; m_w = 32; m_err = 0;
         m_addr = '0; m_data = '0;
      end else begin
         case (m_ph)
            0: if (req_valid) begin
                  m_addr = req_addr; m_rem = (req_size == 0) ? 4 : int'(req_size);
                  m_first = 1; m_err = 0; m_data = '0; m_ph = 1;
               end
            1: if (bus_grant && !bus_busy_in) m_ph = 2;
            2: m_ph = 3;
            3: if (bus_retry) begin
                  if (m_first) m_ph = 1; else begin m_err = 1; m_ph = 4; end
               end else if (bus_ack) begin
                  int w, n;
                  w = m_first ? port_bits(bus_port) : m_w;
                  n = moved(w, m_rem, int'(m_addr[1:0]));
                  for (int i = 0; i < n; i++) begin
                     int x, ln, src;
                     x = int'(m_addr[1:0]) + i;
                     ln = x % 4;
                     src = (w == 32) ? ln : (w == 16) ? (x % 2) : 0;
                     m_data[31-8*ln -: 8] = bus_rdata[31-8*src -: 8];
                  end
                  m_w = w; m_first = 0; m_addr = m_addr + n; m_rem = m_rem - n;
                  m_ph = (m_rem == 0) ? 4 : 2;
               end
            default: m_ph = 0;
         endcase
      end
   end

   bit m_is_read = 0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(req_ready == (m_ph == 0), "R6 req_ready", 32'(req_ready), 32'(m_ph == 0));
         chk(bus_req == (m_ph == 1), "R2 bus_req", 32'(bus_req), 32'(m_ph == 1));
         chk(bus_start == (m_ph == 2), "R3 bus_start", 32'(bus_start), 32'(m_ph == 2));
         chk(bus_busy_out == (m_ph >= 2), "R6 bus_busy_out", 32'(bus_busy_out), 32'(m_ph >= 2));
         chk(rsp_done == (m_ph == 4 && m_err == 0), "R8 rsp_done", 32'(rsp_done), 32'(m_ph == 4 && m_err == 0));
         chk(rsp_err == (m_ph == 4 && m_err == 1), "R10 rsp_err", 32'(rsp_err), 32'(m_ph == 4 && m_err == 1));
         if (m_ph == 2 || m_ph == 3) begin
            chk(bus_addr == m_addr, "R5 bus_addr", bus_addr, m_addr);
            chk(bus_tsize == 2'(m_rem % 4), "R3 bus_tsize", 32'(bus_tsize), 32'(m_rem % 4));
         end
         if (m_ph == 4 && m_err == 0 && m_is_read)
            chk(rsp_rdata == m_data, "R8 rsp_rdata", rsp_rdata, m_data);
      end
   end

   // ---------------- memory and arbitration responder ----------------
   logic [7:0] mem [16];
   int cfg_waits = 0, retry_txn = 0, txn = 0, cnt = 0, gd_cnt = 0;
   bit pending = 0, retried = 0;

   always @(negedge clk) begin
      bus_ack = 1'b0; bus_retry = 1'b0; bus_rdata = 32'hEEEE_EEEE;
      if (gd_cnt > 0) begin
         bus_grant = (gd_cnt <= 2); bus_busy_in = 1'b1; gd_cnt--;
      end else begin
         bus_grant = 1'b1; bus_busy_in = 1'b0;
      end
      if (bus_start) begin
         pending = 1; cnt = cfg_waits; txn++;
      end else if (pending) begin
         if (cnt > 0) cnt--;
         else begin
            pending = 0;
            if (txn == retry_txn && !retried) begin
               bus_retry = 1'b1; retried = 1;
            end else begin
               int w, r, n;
               bus_ack = 1'b1;
               w = port_bits(bus_port);
               r = (bus_tsize == 0) ? 4 : int'(bus_tsize);
               n = moved(w, r, int'(bus_addr[1:0]));
               for (int i = 0; i < n; i++) begin
                  int x, ln;
                  x = int'(bus_addr[3:0]) + i;
                  ln = (w == 32) ? (x % 4) : (w == 16) ? (x % 2) : 0;
                  if (bus_write) mem[x] = bus_wdata[31-8*ln -: 8];
                  else bus_rdata[31-8*ln -: 8] = mem[x];
               end
            end
         end
      end
   end

   // ---------------- scenarios ----------------
   task automatic run(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [1:0] pc, input int waits,
                      input int rtxn, input int gdel, input int exp_txn,
                      input bit exp_err, input int exp_bytes, input string name);
      logic [7:0] snap [16];
      logic [31:0] exp_rd, got_rd;
      bit got_err;
      int nbytes;
      nbytes = (sz == 0) ? 4 : int'(sz);
      @(posedge clk);
      for (int i = 0; i < 16; i++) snap[i] = mem[i];
      cfg_waits = waits; retry_txn = rtxn; retried = 0; txn = 0; gd_cnt = gdel;
      bus_port = pc; m_is_read = !wr;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!(rsp_done || rsp_err)) @(negedge clk);
      got_err = rsp_err; got_rd = rsp_rdata;
      chk(got_err == exp_err, {name, " R9/R10 error flag"}, 32'(got_err), 32'(exp_err));
      chk(txn == exp_txn, {name, " R5 transaction count"}, txn, exp_txn);
      if (wr) begin
         for (int i = 0; i < nbytes; i++) begin
            int x;
            logic [7:0] e;
            x = int'(a[3:0]) + i;
            e = (i < exp_bytes) ? wd[31-8*(x%4) -: 8] : snap[x];
            chk(mem[x] == e, {name, " R7 memory byte"}, 32'(mem[x]), 32'(e));
         end
      end else if (!exp_err) begin
         exp_rd = '0;
         for (int i = 0; i < nbytes; i++) begin
            int x;
            x = int'(a[3:0]) + i;
            exp_rd[31-8*(x%4) -: 8] = snap[x];
         end
         chk(got_rd == exp_rd, {name, " R8 read data"}, got_rd, exp_rd);
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(req_ready && !bus_req && !bus_busy_out && !bus_start && !rsp_done && !rsp_err,
          "R1 reset outputs", {26'd0, req_ready, bus_req, bus_busy_out, bus_start, rsp_done, rsp_err}, 32'h20);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_req && !bus_busy_out && !bus_start,
          "R1 after reset", {28'd0, req_ready, bus_req, bus_busy_out, bus_start}, 32'h8);
      //  wr  addr          size  wdata          port  w  rtx gd txn err bytes
      run(1, 32'h0000_0100, 2'b00, 32'h1122_3344, 2'b00, 0, 0, 0, 1, 0, 4, "word write");
      run(0, 32'h0000_0100, 2'b00, 32'h0,        2'b00, 2, 0, 0, 1, 0, 0, "R4 word read waits");
      run(1, 32'h0000_0104, 2'b00, 32'h5566_7788, 2'b01, 1, 0, 0, 4, 0, 4, "R6 byte port write");
      run(0, 32'h0000_0104, 2'b00, 32'h0,        2'b01, 0, 0, 0, 4, 0, 0, "byte port read");
      run(1, 32'h0000_0108, 2'b00, 32'h99AA_BBCC, 2'b10, 0, 0, 0, 2, 0, 4, "half port write");
      run(0, 32'h0000_0109, 2'b11, 32'h0,        2'b10, 1, 0, 0, 2, 0, 0, "R5 odd half read");
      run(0, 32'h0000_010D, 2'b01, 32'h0,        2'b01, 0, 0, 0, 1, 0, 0, "single byte read");
      run(0, 32'h0000_0102, 2'b10, 32'h0,        2'b01, 0, 0, 0, 2, 0, 0, "pair on byte port");
      run(0, 32'h0000_0100, 2'b00, 32'h0,        2'b01, 1, 1, 0, 5, 0, 0, "R9 first retry");
      run(1, 32'h0000_010C, 2'b00, 32'hDEAD_BEEF, 2'b10, 0, 2, 0, 2, 1, 2, "R10 late retry");
      run(1, 32'h0000_0101, 2'b11, 32'h00F1_F2F3, 2'b00, 0, 0, 5, 1, 0, 3, "R2 delayed grant");
      run(0, 32'h0000_0108, 2'b00, 32'h0,        2'b11, 0, 0, 0, 1, 0, 0, "R5 code 11 as word");
      run(1, 32'h0000_010E, 2'b10, 32'h0000_5A6B, 2'b01, 3, 0, 0, 2, 0, 2, "R7 tail byte write");
      run(0, 32'h0000_010E, 2'b10, 32'h0,        2'b10, 0, 0, 0, 1, 0, 0, "tail half read");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule